// File: doc/BRIEF.md
# Serial Command Shifter with Chain Pass-Through

This block is the serial front end of a small register bank. A host talks to it over a four-wire SPI link in mode 0. A 16-bit frame register collects the bits that arrive while chip select is low. When chip select returns high, the block decodes the most recent complete 16-bit word. The upper byte of that word is the instruction and the lower byte is the data. The block then either writes one register through its register port, or captures a read answer, which is shifted back to the host during the next chip-select frame.

Every bit that enters on the serial input leaves on the serial output exactly 16 clocks later. Several of these blocks can therefore be chained, each serial output feeding the next serial input. The host sends the word for the farthest block first, and all the blocks act together when chip select rises. The serial pins are sampled with synchronisers in the system clock domain. The output can be driven push-pull or open-drain, selected by a mode input that comes from the control register.

Top module: `spi_cmd_shifter`

## Requirements
- R1: While reset is asserted and just after it, `sdo_oe` and `reg_we` are 0.
- R2: Whenever chip select has been high for three or more system clocks, `sdo_oe` is 0.
- R3: Serial input is sampled on SCK rising edges, MSB first, and the output changes on SCK falling edges. Each bit that enters on `sdi` is presented on `sdo` 16 SCK clocks later, so a 32-bit frame returns its first 16 input bits during clocks 17 to 32.
- R4: The instruction byte is `{op[2:0], addr[4:0]}`. Op 110 with an address from 0 to 3 produces one `reg_we` pulse, one system clock long, after chip select rises, with `reg_addr` equal to that address and `reg_wdata` equal to the data byte.
- R5: Op 011 writes the data byte to address 16 (10000b), whatever the instruction's address bits hold.
- R6: Op 100 with address A (0 to 3) causes the next frame to shift out `{3'b111, A}` followed by the contents of register A.
- R7: Op 001 causes the next frame to shift out 0xF0 followed by the contents of the register at address 16.
- R8: A frame that follows a frame with no valid read shifts out zeros for its first 16 bits.
- R9: If chip select rises after a bit count that is zero or not a multiple of 16, no write happens and no read answer is queued.
- R10: An address other than 0 to 3 or 16, used with op 100 or 110, causes no write and no read answer. `reg_we` is only ever raised with a legal address.
- R11: Op 000 (no operation) and the unused ops cause neither a write nor a read answer.
- R12: When `od_mode` is 1, `sdo_oe` is raised only while the output bit is 0, and `sdo` is 0 whenever it is enabled. A high bit is left to the external pull-up.
- R13: When a frame is longer than 16 bits, only the last 16 bits received are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host (asynchronous) |
| cs_n | input | 1 | Active-low chip select (asynchronous) |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output value |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| od_mode | input | 1 | 1 selects open-drain output, 0 selects push-pull |
| reg_addr | output | 5 | Register address toward the register bank |
| reg_wdata | output | 8 | Write data toward the register bank |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 8 | Read data from the bank for `reg_addr`, combinational |

## Verification
Some properties can be watched on every cycle. The output enable stays off while chip select is idle. The write strobe is a single pulse that follows a chip-select rise and always carries a legal address. In open-drain mode the output never drives a high level. Other behaviour can only be shown by the bench's frame scenarios: the contents of read answers, the 16-clock delay through the chain, the zero fill when no answer is pending, and the discarding of short or oddly sized frames, unused addresses and no-ops. The bench compares each write and each returned word against a scoreboard.

// File: rtl/spi_cmd_pkg.sv
// Package: shared widths and operation codes for the serial command shifter.
// Assumes an 8-bit instruction byte followed by an 8-bit data byte.
package spi_cmd_pkg;
    localparam int OP_W   = 3;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;
    localparam int WORD_W = OP_W + ADDR_W + DATA_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP      = 3'b000,
        OP_CTRL_RD  = 3'b001,
        OP_CTRL_WR  = 3'b011,
        OP_REG_RD   = 3'b100,
        OP_REG_WR   = 3'b110
    } op_e;

    localparam logic [OP_W-1:0] RESP_MARK = 3'b111;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes each bit is independent; the reset value is given per bit.
module spi_pin_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one flop stage of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[g] <= RST_VAL;
                else if (g == 0) stage_q[g] <= din;
                else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_shift.sv
// Module: the 16-bit frame register, its bit counter and the output bit.
// Assumes the edge strobes are single-cycle pulses in the clk domain and
// that an SCK edge never coincides with a chip-select edge.
module spi_frame_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic               cs_fall,
    input  logic               sck_rise,
    input  logic               sck_fall,
    input  logic               sdi_bit,
    input  logic [FRAME_W-1:0] load_word,
    output logic [FRAME_W-1:0] frame,
    output logic               frame_ok,
    output logic               sdo_bit
);
    localparam int CNT_W = $clog2(FRAME_W);

    logic [CNT_W-1:0] bit_cnt;
    logic             seen_full;

    // Purpose: load on frame start, shift left on each SCK rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame     <= '0;
            bit_cnt   <= '0;
            seen_full <= 1'b0;
        end else if (cs_fall) begin
            frame     <= load_word;
            bit_cnt   <= '0;
            seen_full <= 1'b0;
        end else if (active && sck_rise) begin
            frame   <= {frame[FRAME_W-2:0], sdi_bit};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(FRAME_W-1)) seen_full <= 1'b1;
        end
    end

    // Purpose: present the frame MSB at start and after each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                    sdo_bit <= 1'b0;
        else if (cs_fall)              sdo_bit <= load_word[FRAME_W-1];
        else if (active && sck_fall)   sdo_bit <= frame[FRAME_W-1];
    end

    assign frame_ok = seen_full && (bit_cnt == '0);
endmodule

// File: rtl/spi_cmd_decode.sv
// Module: decodes the frame on chip-select rise, issues writes and holds
// the pending read answer for the next frame.
// Assumes reg_rdata follows reg_addr combinationally.
module spi_cmd_decode
    import spi_cmd_pkg::*;
#(
    parameter int NUM_REGS  = 4,
    parameter int CTRL_ADDR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic [WORD_W-1:0] frame,
    input  logic              frame_ok,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic [WORD_W-1:0] load_word
);
    op_e               op;
    logic [ADDR_W-1:0] raw_addr;
    logic              is_wr, is_rd, addr_ok;
    logic              pend_q;
    logic [WORD_W-1:0] resp_q;

    // Purpose: split the frame and resolve the target address.
    always_comb begin
        op        = op_e'(frame[WORD_W-1 -: OP_W]);
        raw_addr  = frame[DATA_W +: ADDR_W];
        reg_wdata = frame[DATA_W-1:0];
        is_wr     = (op == OP_CTRL_WR) || (op == OP_REG_WR);
        is_rd     = (op == OP_CTRL_RD) || (op == OP_REG_RD);
        if (op == OP_CTRL_WR || op == OP_CTRL_RD) reg_addr = ADDR_W'(CTRL_ADDR);
        else                                      reg_addr = raw_addr;
        addr_ok   = (reg_addr < ADDR_W'(NUM_REGS)) || (reg_addr == ADDR_W'(CTRL_ADDR));
    end

    assign reg_we = cs_rise && frame_ok && is_wr && addr_ok;

    // Purpose: capture a read answer and release it at the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            resp_q <= '0;
        end else if (cs_rise && frame_ok && is_rd && addr_ok) begin
            pend_q <= 1'b1;
            resp_q <= {RESP_MARK, reg_addr, reg_rdata};
        end else if (cs_fall) begin
            pend_q <= 1'b0;
        end
    end

    assign load_word = pend_q ? resp_q : '0;
endmodule

// File: rtl/spi_cmd_shifter.sv
// Module: top of the serial command shifter. Synchronises the pins,
// detects edges, and drives the pad in push-pull or open-drain form.
// Assumes clk runs at least 8x faster than sck.
module spi_cmd_shifter
    import spi_cmd_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int CTRL_ADDR   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              od_mode,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata
);
    logic [2:0]        pins_s;
    logic              cs_s, sck_s, sdi_s;
    logic              cs_d, sck_d;
    logic              cs_rise, cs_fall, sck_rise, sck_fall, active;
    logic [WORD_W-1:0] frame, load_word;
    logic              frame_ok, sdo_bit;

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({cs_n, sck, sdi}), .dout(pins_s)
    );
    assign {cs_s, sck_s, sdi_s} = pins_s;

    // Purpose: delayed copies of the synchronised pins for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d  <= 1'b1;
            sck_d <= 1'b0;
        end else begin
            cs_d  <= cs_s;
            sck_d <= sck_s;
        end
    end

    assign cs_rise  = cs_s & ~cs_d;
    assign cs_fall  = ~cs_s & cs_d;
    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign active   = ~cs_s;

    spi_frame_shift #(.FRAME_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .active(active), .cs_fall(cs_fall),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_bit(sdi_s),
        .load_word(load_word), .frame(frame), .frame_ok(frame_ok),
        .sdo_bit(sdo_bit)
    );

    spi_cmd_decode #(.NUM_REGS(NUM_REGS), .CTRL_ADDR(CTRL_ADDR)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_rise(cs_rise), .cs_fall(cs_fall),
        .frame(frame), .frame_ok(frame_ok), .reg_rdata(reg_rdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .load_word(load_word)
    );

    assign sdo_oe = active & (~od_mode | ~sdo_bit);
    assign sdo    = od_mode ? 1'b0 : sdo_bit;
endmodule

// File: rtl/spi_cmd_shifter_chk.sv
// Module: property checker for the serial command shifter, bound to the top.
// Assumes only the top-level ports are observed.
module spi_cmd_shifter_chk #(
    parameter int NUM_REGS  = 4,
    parameter int CTRL_ADDR = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       sdo,
    input logic       sdo_oe,
    input logic       od_mode,
    input logic [4:0] reg_addr,
    input logic       reg_we
);
    p_hiz_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n, 1) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe);

    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    p_we_after_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(cs_n));

    p_we_addr_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ((reg_addr < 5'(NUM_REGS)) || (reg_addr == 5'(CTRL_ADDR))));

    p_od_low_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (od_mode && sdo_oe) |-> !sdo);
endmodule

bind spi_cmd_shifter spi_cmd_shifter_chk #(.NUM_REGS(NUM_REGS), .CTRL_ADDR(CTRL_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe),
    .od_mode(od_mode), .reg_addr(reg_addr), .reg_we(reg_we)
);

// File: tb/tb_spi_cmd_shifter.sv
module tb_spi_cmd_shifter;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, sdi = 1'b0, od_mode = 1'b0;
    logic       sdo, sdo_oe, reg_we;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic [7:0] bank [32];
    logic       sdo_line;

    int n_checks = 0, n_fail = 0, n_writes = 0;
    bit done = 0;
    bit od_violation = 0;
    logic [12:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_shifter dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .od_mode(od_mode), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = bank[reg_addr];
    assign sdo_line  = sdo_oe ? sdo : 1'b1;

    // Register bank model of the environment
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) bank[i] <= 8'h40;
        end else if (reg_we) begin
            bank[reg_addr] <= reg_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected writes from the scoreboard
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            n_writes++;
            if (exp_q.size() == 0) begin
                check(0, "R9/R10/R11 unexpected write", {19'd0, reg_addr, reg_wdata}, 32'h0);
            end else begin
                logic [12:0] e;
                e = exp_q.pop_front();
                check({reg_addr, reg_wdata} == e, "R4/R5 write", {19'd0, reg_addr, reg_wdata}, {19'd0, e});
            end
        end
        if (od_mode && sdo_oe && sdo) od_violation = 1;
    end

    task automatic frame_xfer(input logic [31:0] w, input int nbits, output logic [31:0] got);
        got = '0;
        cs_n = 1'b0;
        repeat (HALF_SCK) @(posedge clk);
        for (int i = 0; i < nbits; i++) begin
            sdi = w[nbits-1-i];
            repeat (HALF_SCK) @(posedge clk);
            got = {got[30:0], sdo_line};
            sck = 1'b1;
            repeat (HALF_SCK) @(posedge clk);
            sck = 1'b0;
        end
        repeat (HALF_SCK) @(posedge clk);
        cs_n = 1'b1;
        repeat (10) @(posedge clk);
    endtask

    task automatic expect_write(input logic [4:0] a, input logic [7:0] d);
        exp_q.push_back({a, d});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        int wbase;
        repeat (4) @(posedge clk);
        #1;
        check(sdo_oe == 0 && reg_we == 0, "R1 reset outputs", {sdo_oe, reg_we}, 0);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check(sdo_oe == 0 && reg_we == 0, "R1 after reset", {sdo_oe, reg_we}, 0);

        // R4 write wiper 2; R8 no pending answer
        expect_write(5'd2, 8'h5A);
        frame_xfer({16'd0, 8'b110_00010, 8'h5A}, 16, got);
        check(got[15:0] == 16'h0000, "R8 zero fill", got, 0);
        #1;
        check(sdo_oe == 0, "R2 idle hi-z", sdo_oe, 0);

        // R6 read wiper 2
        frame_xfer({16'd0, 8'b100_00010, 8'h00}, 16, got);
        frame_xfer(32'h0, 16, got);
        check(got[15:0] == 16'hE25A, "R6 read answer", got, 32'hE25A);

        // R5 control write ignores address bits; R7 control read
        expect_write(5'd16, 8'h42);
        frame_xfer({16'd0, 8'b011_00111, 8'h42}, 16, got);
        frame_xfer({16'd0, 8'b001_01010, 8'h00}, 16, got);
        frame_xfer(32'h0, 16, got);
        check(got[15:0] == 16'hF042, "R7 control read", got, 32'hF042);

        // R9 short and odd-length frames
        wbase = n_writes;
        frame_xfer({20'd0, 12'b110_00001_1111}, 12, got);
        frame_xfer({15'd0, 17'b1_1100_0001_0001_0001}, 17, got);
        frame_xfer({16'd0, 8'b100_00001, 8'h00}, 15, got);
        frame_xfer(32'h0, 16, got);
        check(n_writes == wbase && got[15:0] == 0, "R9 partial frames ignored", got, 0);
        frame_xfer(32'h0, 0, got);
        frame_xfer(32'h0, 16, got);
        check(n_writes == wbase && got[15:0] == 0, "R9 empty frame ignored", got, 0);

        // R10 unused address
        frame_xfer({16'd0, 8'b110_00101, 8'h99}, 16, got);
        frame_xfer({16'd0, 8'b100_00101, 8'h00}, 16, got);
        frame_xfer(32'h0, 16, got);
        check(n_writes == wbase && got[15:0] == 0, "R10 unused address", got, 0);

        // R11 NOP and unused ops
        frame_xfer({16'd0, 8'b000_00001, 8'h11}, 16, got);
        frame_xfer({16'd0, 8'b111_00001, 8'h22}, 16, got);
        frame_xfer({16'd0, 8'b010_00001, 8'h33}, 16, got);
        check(n_writes == wbase && got[15:0] == 0, "R11 nop no effect", got, 0);

        // R3/R13 chained 32-bit frame: last word executes, first word passes through
        expect_write(5'd0, 8'h77);
        frame_xfer({16'hABCD, 8'b110_00000, 8'h77}, 32, got);
        check(got == 32'h0000ABCD, "R3 chain pass-through", got, 32'h0000ABCD);
        frame_xfer({16'd0, 8'b100_00000, 8'h00}, 16, got);
        frame_xfer(32'h0, 16, got);
        check(got[15:0] == 16'hE077, "R13 last word decoded", got, 32'hE077);

        // R12 open-drain output
        od_mode = 1'b1;
        od_violation = 0;
        frame_xfer({16'd0, 8'b100_00010, 8'h00}, 16, got);
        frame_xfer(32'h0, 16, got);
        check(got[15:0] == 16'hE25A, "R12 open-drain data", got, 32'hE25A);
        check(od_violation == 0, "R12 never drives high", od_violation, 0);
        od_mode = 1'b0;
        #1;
        check(sdo_oe == 0, "R2 idle hi-z end", sdo_oe, 0);

        repeat (5) @(posedge clk);
        check(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule